// File: doc/BRIEF.md
# Operand-Initialized Two-Stage Binary Adder

This block adds two unsigned N-bit operands and returns the full N+1-bit sum. It has no carry input and no handshake. The operands go in, the sum comes out, either in the same cycle or after one register stage, chosen by a parameter.

The adder works in two stages.

The first stage builds two per-bit vectors, a partial sum and a partial carry. Both start as a copy of operand `b`. Where a bit of `a` is high, the partial sum bit is inverted. Where a bit of `a` is low, the partial carry bit is cleared. As a result, the partial sum equals `a ^ b` and the partial carry equals `a & b`.

The second stage moves the partial carry one place up in weight and merges it with the partial sum. The merge uses a chain of selection cells. Each cell takes one partial sum bit, the partial carry from the bit below it, and the ripple carry from the cell below it. The cell picks its carry-out first, and picks the result bit afterwards from the same two selectors.

The ends of the chain are handled directly:
- Bit 0 of the result is the partial sum bit 0, with no cell.
- The top bit of the result joins the highest partial carry with the last ripple carry.

The width N must be 2 or more.

Top module: `opinit_adder`

## Requirements
- R1: `sum` equals the exact unsigned value `a + b` as an N+1-bit number, for every pair of operands.
- R2: `sum[0]` equals `a[0] ^ b[0]` for every pair of operands.
- R3: `sum[N]` is 1 exactly when `a + b` is 2^N or more. It is always 1 when `a[N-1]` and `b[N-1]` are both 1, and always 0 when both are 0.
- R4: All-ones plus all-ones gives 2^(N+1) - 2, and zero plus zero gives 0.
- R5: A carry generated at bit 0 travels the whole chain. All-ones plus one gives exactly 2^N.
- R6: With `REG_OUT` = 1, `sum` shows the sum of the operands present at the previous rising edge of `clk`, and it holds its value between edges. With `REG_OUT` = 0, `sum` follows the operands with no clock involved.
- R7: With `REG_OUT` = 1, `sum` is 0 while `rst_n` is low.
- R8: For N = 4, all 256 operand pairs give the correct sum, including the example 1011 + 1001 = 10100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Active-low reset; clears the output register |
| a | input | N | First unsigned operand |
| b | input | N | Second unsigned operand |
| sum | output | N+1 | Unsigned sum; the top bit is the carry out |

## Verification
On every enabled clock edge, the assertions check three things:
- the merged result against the arithmetic sum;
- result bit 0 against the exclusive-or of the operands' low bits;
- the carry-out bit against the operands' top bits.

In the registered variant they also check that the output matches the operands of one edge earlier.

Some behaviour only the bench's scenarios can show:
- that the output really holds between edges;
- that reset clears the output;
- that a carry travels all the way along the chain;
- that every one of the 256 four-bit operand pairs is correct.

// File: rtl/opinit_adder.sv
module opinit_adder #(
  parameter int N       = 32,
  parameter bit REG_OUT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N:0]   sum
);

  logic [N-1:0] ps;
  logic [N-1:0] pc;
  logic [N-1:0] rip;
  logic [N:0]   res;

  // Stage one: start from b, then adjust each bit with a.
  always_comb begin
    ps = b;
    pc = b;
    for (int i = 0; i < N; i++) begin
      if (a[i]) ps[i] = ~b[i];
      else      pc[i] = 1'b0;
    end
  end

  // Bit 0 has no partial carry and no ripple carry coming in.
  assign res[0] = ps[0];
  assign rip[0] = 1'b0;

  // Stage two: selection cells, each choosing its carry-out first.
  genvar gi;
  generate
    for (gi = 1; gi < N; gi++) begin : g_cell
      logic s_in, c_in, r_in;
      assign s_in = ps[gi];
      assign c_in = pc[gi-1];
      assign r_in = rip[gi-1];
      assign rip[gi] = c_in ? (r_in ? 1'b1 : s_in) : (r_in ? s_in : 1'b0);
      assign res[gi] = (c_in == r_in) ? s_in : ~s_in;
    end
  endgenerate

  // The two inputs of the top bit are never both 1, so an OR is enough.
  assign res[N] = pc[N-1] | rip[N-1];

  generate
    if (REG_OUT) begin : g_reg
      logic [N:0] sum_q;
      logic       primed_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sum_q    <= '0;
          primed_q <= 1'b0;
        end else begin
          sum_q    <= res;
          primed_q <= 1'b1;
        end
      end

      assign sum = sum_q;

      AST_REG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> (sum == ({1'b0, $past(a)} + {1'b0, $past(b)}))); // R6
    end else begin : g_comb
      assign sum = res;
    end
  endgenerate

  AST_FULL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    res == ({1'b0, a} + {1'b0, b})); // R1
  AST_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    res[0] == (a[0] ^ b[0])); // R2
  AST_TOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (a[N-1] && b[N-1]) |-> res[N]); // R3
  AST_TOP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!a[N-1] && !b[N-1]) |-> !res[N]); // R3

endmodule

// File: tb/tb_opinit_adder.sv
module tb_opinit_adder;
  localparam int W  = 32;
  localparam int WS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0]  a, b;
  logic [W:0]    sum;
  logic [WS-1:0] sa, sb;
  logic [WS:0]   ssum;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opinit_adder #(.N(W), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .sum(sum));

  opinit_adder #(.N(WS), .REG_OUT(1'b0)) dut_small (
    .clk(clk), .rst_n(rst_n), .a(sa), .b(sb), .sum(ssum));

  task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drives the registered dut, waits for the capture edge, then checks it.
  task automatic big_add(input string tag, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    a = x; b = y;
    @(posedge clk); #1;
    check(tag, sum, {1'b0, x} + {1'b0, y});
  endtask

  task automatic t_reset;
    a = '1; b = '1; sa = '0; sb = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R7 reset clears sum", sum, '0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_corners;
    big_add("R4 ones+ones", '1, '1);
    check("R4 ones+ones value", sum, {1'b1, {(W-1){1'b1}}, 1'b0});
    check("R3 carry out set", {{W{1'b0}}, sum[W]}, 1);
    big_add("R4 zero+zero", '0, '0);
    check("R4 zero value", sum, '0);
    big_add("R5 ones+one", '1, 1);
    check("R5 full ripple", sum, {1'b1, {W{1'b0}}});
    big_add("R5 one+ones", 1, '1);
    big_add("R3 no carry out", 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    check("R3 top clear", {{W{1'b0}}, sum[W]}, 0);
    big_add("R1 alternating", 32'hAAAA_AAAA, 32'h5555_5555);
    big_add("R1 alt shifted", 32'hAAAA_AAAA, 32'hAAAA_AAAA);
    big_add("R1 example", 32'hB, 32'h9);
    check("R2 low bit", {{W{1'b0}}, sum[0]}, {{W{1'b0}}, 1'b0});
  endtask

  task automatic t_random;
    for (int k = 0; k < 2000; k++) begin
      logic [W-1:0] x, y;
      x = $urandom; y = $urandom;
      if (k % 4 == 1) y = ~x;
      if (k % 4 == 2) y = (~x) + 1;
      big_add("R1 random", x, y);
      check("R2 random low bit", {{W{1'b0}}, sum[0]}, {{W{1'b0}}, x[0] ^ y[0]});
    end
  endtask

  task automatic t_reg_timing;
    @(negedge clk);
    a = 32'h1234_5678; b = 32'h1111_1111;
    @(posedge clk);
    @(negedge clk);
    a = 32'hFFFF_0000; b = 32'h0001_0000;
    #1 check("R6 holds before edge", sum, 33'h0_2345_6789);
    @(posedge clk); #1;
    check("R6 updates after edge", sum, 33'h1_0000_0000);
  endtask

  task automatic t_small_exhaustive;
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        sa = i[WS-1:0]; sb = j[WS-1:0];
        #1;
        check("R8 exhaustive", {{(W-WS){1'b0}}, ssum}, W'(i + j));
      end
    end
    sa = 4'b1011; sb = 4'b1001;
    #1 check("R8 example 10100", {{(W-WS){1'b0}}, ssum}, 33'b10100);
    check("R6 comb follows inputs", {{(W-WS){1'b0}}, ssum}, 33'd20);
  endtask

  initial begin
    t_reset();
    t_corners();
    t_reg_timing();
    t_random();
    t_small_exhaustive();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule